// File: doc/BRIEF.md
# Two-Level Ternary CAM Search Engine

This block is a small ternary content-addressable memory for packet classification. Storage is organised as blocks of entries. Every block has a short exact-match tag, and every entry holds a base-width word stored as value/care bit pairs. A search runs in two stages. The optional primary stage compares a tag key against every block tag. The secondary stage compares the wide key only against entries in blocks that passed the primary stage. During that compare, a global search mask removes chosen key bit positions.

One command can search groups of 1, 2, 4 or 8 adjacent base entries as a single wider word. The blocks are divided between two banks by a programmable split point. Both banks are searched in the same cycle, and each bank reports its own lowest-index winner. The supported commands are entry writes through a per-bit write-protect mask, tag writes, mask loads, split loads and searches.

The control is a two-state machine. In `S_IDLE` no result is being presented. In `S_REPORT` the results of the search accepted on the previous edge are presented. The transition `go_report` is taken from either state whenever a search command is accepted. The transition `go_idle` is taken from either state on any other cycle.

Top module: `tcam_two_level`

## Requirements
- R1: Each entry stores a value/care pair per bit. A bit with care 0 matches either key value. After reset every entry holds value 0 with every bit cared. Opcode 1 writes `cmd_data`/`cmd_care` into entry `cmd_addr`.
- R2: During a search, a key bit whose global search mask bit is 1 takes no part in the compare. Opcode 3 loads this mask from `cmd_data`. Its reset value is 0.
- R3: During an entry write, a bit whose write mask bit is 1 keeps its previous value and care. Opcode 4 loads this mask from `cmd_data`. Its reset value is 0.
- R4: Opcode 2 writes `cmd_tag` to the tag of block `cmd_addr[4:3]`, and tags reset to 0. When `cmd_tag_en` is 1, only entries whose block tag equals `cmd_tag` can hit. When `cmd_tag_en` is 0, every block is searched.
- R5: `cmd_width` = 0, 1, 2 or 3 selects a group span of 1, 2, 4 or 8 entries. Only groups whose base index is a multiple of the span can hit. Entry base+j is compared with key bits `[j*72 +: 72]`. The group hits only if all of its entries match, and the reported index is the group base.
- R6: Within each bank the lowest matching index wins. A bank with no match reports hit 0 and index 0.
- R7: Opcode 5 loads a split value s from `cmd_addr[2:0]`, and values above 4 act as 4. Blocks below s form bank 0 (`res_hit[0]`, `res_idx0`) and the other blocks form bank 1 (`res_hit[1]`, `res_idx1`). The reset value of s is 4.
- R8: Opcode 6 is a search. `res_valid` is 1 exactly in the cycle after a search is accepted. The hit flags and indices are registered at that edge and hold until the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | 5 | Entry index, block index in [4:3], or split value |
| cmd_width | input | 2 | Search span code |
| cmd_tag | input | 4 | Tag to write or tag key |
| cmd_tag_en | input | 1 | Enables the primary tag stage |
| cmd_data | input | 72 | Write value or mask to load |
| cmd_care | input | 72 | Write care bits |
| cmd_key | input | 576 | Search key, one 72-bit slice per group member |
| res_valid | output | 1 | Results presented this cycle |
| res_hit | output | 2 | Per-bank hit flags |
| res_idx0 | output | 5 | Bank 0 winning index |
| res_idx1 | output | 5 | Bank 1 winning index |

## Verification
The hardest case to reach is a wide lookup that lines up in content but not in alignment. A pattern is laid across entries 19 and 20, which straddle a span boundary, next to a correctly aligned copy at 16 and 17. Breaking the aligned copy must then give a miss rather than a hit at the misaligned pair. The tag filter is tested by placing equal entries in blocks with different tags. The bank split is tested by placing equal entries on both sides of several split values, including the clamped value. Each of these cases is compared against an independent model that the bench updates on every write.

// File: rtl/tcam2_pkg.sv
package tcam2_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_WR_ENTRY  = 3'd1,
        OP_WR_TAG    = 3'd2,
        OP_SET_GMASK = 3'd3,
        OP_SET_WMASK = 3'd4,
        OP_SET_SPLIT = 3'd5,
        OP_SEARCH    = 3'd6
    } op_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } st_e;

    localparam int SPAN_CODES = 4;
    localparam int MAX_SPAN   = 1 << (SPAN_CODES - 1);
endpackage

// File: rtl/tcam2_store.sv
module tcam2_store #(
    parameter int KEY_W  = 72,
    parameter int TAG_W  = 4,
    parameter int BLOCKS = 4,
    parameter int EPB    = 8,
    localparam int N     = BLOCKS * EPB,
    localparam int AW    = $clog2(N),
    localparam int EW    = $clog2(EPB),
    localparam int SW    = $clog2(BLOCKS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_entry,
    input  logic                          wr_tag,
    input  logic                          set_gmask,
    input  logic                          set_wmask,
    input  logic                          set_split,
    input  logic [AW-1:0]                 addr,
    input  logic [KEY_W-1:0]              data,
    input  logic [KEY_W-1:0]              care,
    input  logic [TAG_W-1:0]              tag,
    output logic [N-1:0][KEY_W-1:0]       ent_val,
    output logic [N-1:0][KEY_W-1:0]       ent_care,
    output logic [BLOCKS-1:0][TAG_W-1:0]  blk_tag,
    output logic [KEY_W-1:0]              gmask,
    output logic [SW-1:0]                 split_q
);
    logic [KEY_W-1:0] wmask;
    logic [SW-1:0]    split_in;

    assign split_in = (addr[SW-1:0] > SW'(BLOCKS)) ? SW'(BLOCKS) : addr[SW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                ent_val[i]  <= '0;
                ent_care[i] <= '1;
            end
        end else if (wr_entry) begin
            for (int i = 0; i < N; i++) begin
                if (addr == AW'(i)) begin
                    ent_val[i]  <= (ent_val[i]  & wmask) | (data & ~wmask);
                    ent_care[i] <= (ent_care[i] & wmask) | (care & ~wmask);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) blk_tag[b] <= '0;
        end else if (wr_tag) begin
            for (int b = 0; b < BLOCKS; b++) begin
                if (addr[AW-1:EW] == (AW-EW)'(b)) blk_tag[b] <= tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask   <= '0;
            wmask   <= '0;
            split_q <= SW'(BLOCKS);
        end else begin
            if (set_gmask) gmask   <= data;
            if (set_wmask) wmask   <= data;
            if (set_split) split_q <= split_in;
        end
    end
endmodule

// File: rtl/tcam2_match.sv
module tcam2_match
    import tcam2_pkg::*;
#(
    parameter int KEY_W  = 72,
    parameter int TAG_W  = 4,
    parameter int BLOCKS = 4,
    parameter int EPB    = 8,
    localparam int N     = BLOCKS * EPB
) (
    input  logic [N-1:0][KEY_W-1:0]       ent_val,
    input  logic [N-1:0][KEY_W-1:0]       ent_care,
    input  logic [BLOCKS-1:0][TAG_W-1:0]  blk_tag,
    input  logic [KEY_W-1:0]              gmask,
    input  logic [KEY_W*MAX_SPAN-1:0]     key,
    input  logic [TAG_W-1:0]              tag_key,
    input  logic                          tag_en,
    input  logic [1:0]                    width,
    output logic [N-1:0]                  grp_hit
);
    logic [BLOCKS-1:0]           blk_ok;
    logic [SPAN_CODES-1:0][N-1:0] ent_hit;
    logic [SPAN_CODES-1:0][N-1:0] grp_w;

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        assign blk_ok[b] = !tag_en || (blk_tag[b] == tag_key);
    end

    for (genvar w = 0; w < SPAN_CODES; w++) begin : g_w
        localparam int SPAN = 1 << w;
        for (genvar i = 0; i < N; i++) begin : g_e
            localparam int OFS = i % SPAN;
            assign ent_hit[w][i] =
                &(~ent_care[i] | gmask | ~(ent_val[i] ^ key[OFS*KEY_W +: KEY_W]));
            if (OFS == 0) begin : g_base
                assign grp_w[w][i] = (&ent_hit[w][i +: SPAN]) & blk_ok[i / EPB];
            end else begin : g_inner
                assign grp_w[w][i] = 1'b0;
            end
        end
    end

    assign grp_hit = grp_w[width];
endmodule

// File: rtl/tcam2_prio.sv
module tcam2_prio #(
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_two_level.sv
module tcam_two_level
    import tcam2_pkg::*;
#(
    parameter int KEY_W  = 72,
    parameter int TAG_W  = 4,
    parameter int BLOCKS = 4,
    parameter int EPB    = 8,
    localparam int N     = BLOCKS * EPB,
    localparam int AW    = $clog2(N),
    localparam int SW    = $clog2(BLOCKS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [AW-1:0]             cmd_addr,
    input  logic [1:0]                cmd_width,
    input  logic [TAG_W-1:0]          cmd_tag,
    input  logic                      cmd_tag_en,
    input  logic [KEY_W-1:0]          cmd_data,
    input  logic [KEY_W-1:0]          cmd_care,
    input  logic [KEY_W*MAX_SPAN-1:0] cmd_key,
    output logic                      res_valid,
    output logic [1:0]                res_hit,
    output logic [AW-1:0]             res_idx0,
    output logic [AW-1:0]             res_idx1
);
    op_e op;
    st_e state_q, state_d;
    logic is_search;

    logic [N-1:0][KEY_W-1:0]      ent_val, ent_care;
    logic [BLOCKS-1:0][TAG_W-1:0] blk_tag;
    logic [KEY_W-1:0]             gmask;
    logic [SW-1:0]                split_q;
    logic [N-1:0]                 grp_hit;
    logic [N-1:0]                 in_bank0;
    logic [1:0][N-1:0]            bank_req;
    logic [1:0]                   bank_found;
    logic [1:0][AW-1:0]           bank_idx;

    assign op        = op_e'(cmd_op);
    assign is_search = cmd_valid && (op == OP_SEARCH);

    tcam2_store #(.KEY_W(KEY_W), .TAG_W(TAG_W), .BLOCKS(BLOCKS), .EPB(EPB)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_entry (cmd_valid && op == OP_WR_ENTRY),
        .wr_tag   (cmd_valid && op == OP_WR_TAG),
        .set_gmask(cmd_valid && op == OP_SET_GMASK),
        .set_wmask(cmd_valid && op == OP_SET_WMASK),
        .set_split(cmd_valid && op == OP_SET_SPLIT),
        .addr     (cmd_addr),
        .data     (cmd_data),
        .care     (cmd_care),
        .tag      (cmd_tag),
        .ent_val  (ent_val),
        .ent_care (ent_care),
        .blk_tag  (blk_tag),
        .gmask    (gmask),
        .split_q  (split_q)
    );

    tcam2_match #(.KEY_W(KEY_W), .TAG_W(TAG_W), .BLOCKS(BLOCKS), .EPB(EPB)) u_match (
        .ent_val (ent_val),
        .ent_care(ent_care),
        .blk_tag (blk_tag),
        .gmask   (gmask),
        .key     (cmd_key),
        .tag_key (cmd_tag),
        .tag_en  (cmd_tag_en),
        .width   (cmd_width),
        .grp_hit (grp_hit)
    );

    for (genvar i = 0; i < N; i++) begin : g_bank_sel
        assign in_bank0[i] = SW'(i / EPB) < split_q;
    end

    assign bank_req[0] = grp_hit & in_bank0;
    assign bank_req[1] = grp_hit & ~in_bank0;

    for (genvar k = 0; k < 2; k++) begin : g_bank
        tcam2_prio #(.N(N)) u_prio (
            .req  (bank_req[k]),
            .found(bank_found[k]),
            .idx  (bank_idx[k])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = is_search ? S_REPORT : S_IDLE;
            S_REPORT: state_d = is_search ? S_REPORT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit  <= '0;
            res_idx0 <= '0;
            res_idx1 <= '0;
        end else if (is_search) begin
            res_hit  <= bank_found;
            res_idx0 <= bank_idx[0];
            res_idx1 <= bank_idx[1];
        end
    end

    assign res_valid = (state_q == S_REPORT);
endmodule

// File: rtl/tcam2_chk.sv
module tcam2_chk #(
    parameter int N   = 32,
    parameter int EPB = 8,
    parameter int SW  = 3,
    localparam int AW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [1:0]    cmd_width,
    input logic          res_valid,
    input logic [1:0]    res_hit,
    input logic [AW-1:0] res_idx0,
    input logic [AW-1:0] res_idx1,
    input logic [SW-1:0] split_q
);
    logic srch;
    assign srch = cmd_valid && (cmd_op == 3'd6);

    function automatic logic [AW-1:0] low_bits(input logic [1:0] w);
        return AW'((1 << w) - 1);
    endfunction

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        srch |=> res_valid);
    assert_valid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !srch |=> !res_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !srch |=> ($stable(res_hit) && $stable(res_idx0) && $stable(res_idx1)));
    assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        srch |=> ((!res_hit[0] || (res_idx0 & low_bits($past(cmd_width))) == '0) &&
                  (!res_hit[1] || (res_idx1 & low_bits($past(cmd_width))) == '0)));
    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_hit[0] || res_idx0 == '0) && (res_hit[1] || res_idx1 == '0)));
    assert_bank_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srch |=> ((!res_hit[0] || int'(res_idx0) / EPB <  int'($past(split_q))) &&
                  (!res_hit[1] || int'(res_idx1) / EPB >= int'($past(split_q)))));
endmodule

bind tcam_two_level tcam2_chk #(.N(N), .EPB(EPB), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_width(cmd_width),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_idx0 (res_idx0),
    .res_idx1 (res_idx1),
    .split_q  (split_q)
);

// File: tb/tcam_two_level_tb.sv
`timescale 1ns/1ps
module tcam_two_level_tb;
    localparam int KW = 72, NB = 4, EPB = 8, N = NB * EPB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_tag_en = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [4:0] cmd_addr = '0;
    logic [1:0] cmd_width = '0;
    logic [3:0] cmd_tag = '0;
    logic [KW-1:0] cmd_data = '0, cmd_care = '0;
    logic [KW*8-1:0] cmd_key = '0;
    logic res_valid;
    logic [1:0] res_hit;
    logic [4:0] res_idx0, res_idx1;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tcam_two_level u_dut (.*);

    // reference model
    logic [KW-1:0] m_val [N];
    logic [KW-1:0] m_care[N];
    logic [3:0]    m_tag [NB];
    logic [KW-1:0] m_gmask, m_wmask;
    int            m_split;

    typedef struct { logic [1:0] hit; logic [4:0] i0; logic [4:0] i1; string req; } exp_t;
    exp_t sb[$];

    localparam logic [KW-1:0] VA = 72'h0123456789ABCDEF01;
    localparam logic [KW-1:0] VB = 72'hFEDCBA987654321011;
    localparam logic [KW-1:0] VC = 72'h5A5A5A5A5A5A5A5A5A;
    localparam logic [KW-1:0] ONES = '1;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [4:0] a, input logic [KW-1:0] d,
                         input logic [KW-1:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_care = c;
        cmd_tag_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic wr_entry(input int a, input logic [KW-1:0] d, input logic [KW-1:0] c);
        drive(3'd1, 5'(a), d, c);
        m_val[a]  = (m_val[a]  & m_wmask) | (d & ~m_wmask);
        m_care[a] = (m_care[a] & m_wmask) | (c & ~m_wmask);
    endtask

    task automatic wr_tag(input int b, input logic [3:0] t);
        drive(3'd2, 5'(b * EPB), '0, '0);
        cmd_tag = t;
        m_tag[b] = t;
    endtask

    task automatic set_gmask(input logic [KW-1:0] m);
        drive(3'd3, '0, m, '0); m_gmask = m;
    endtask

    task automatic set_wmask(input logic [KW-1:0] m);
        drive(3'd4, '0, m, '0); m_wmask = m;
    endtask

    task automatic set_split(input int s);
        drive(3'd5, 5'(s), '0, '0); m_split = (s > NB) ? NB : s;
    endtask

    function automatic exp_t model(input logic [KW*8-1:0] key, input int w,
                                   input logic [3:0] tg, input logic ten, input string r);
        exp_t e;
        int span;
        logic ok;
        int bk;
        e.hit = '0; e.i0 = '0; e.i1 = '0; e.req = r;
        span = 1 << w;
        for (int b = 0; b < N; b += span) begin
            ok = !(ten && m_tag[b / EPB] != tg);
            for (int j = 0; j < span; j++)
                if (((m_val[b+j] ^ key[j*KW +: KW]) & m_care[b+j] & ~m_gmask) != '0) ok = 1'b0;
            bk = ((b / EPB) < m_split) ? 0 : 1;
            if (ok && !e.hit[bk]) begin
                e.hit[bk] = 1'b1;
                if (bk == 0) e.i0 = 5'(b); else e.i1 = 5'(b);
            end
        end
        return e;
    endfunction

    task automatic search(input logic [KW*8-1:0] key, input int w, input logic [3:0] tg,
                          input logic ten, input string r);
        drive(3'd6, '0, '0, '0);
        cmd_key = key; cmd_width = 2'(w); cmd_tag = tg; cmd_tag_en = ten;
        sb.push_back(model(key, w, tg, ten, r));
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
                chk("R8 unexpected valid", 32'(res_valid), 32'd0);
            end else begin
                e = sb.pop_front();
                chk({e.req, " hit"},  32'(res_hit),  32'(e.hit));
                chk({e.req, " idx0"}, 32'(res_idx0), 32'(e.i0));
                chk({e.req, " idx1"}, 32'(res_idx1), 32'(e.i1));
            end
        end
    end

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [KW*8-1:0] k;
        logic [1:0] held;
        for (int i = 0; i < N; i++) begin m_val[i] = '0; m_care[i] = '1; end
        for (int b = 0; b < NB; b++) m_tag[b] = '0;
        m_gmask = '0; m_wmask = '0; m_split = NB;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset valid", 32'(res_valid), 32'd0);
        chk("R6 reset hit", 32'(res_hit), 32'd0);

        search({504'b0, VA}, 0, 0, 0, "R1 reset miss");
        wr_entry(5, VA, ONES);
        search({504'b0, VA}, 0, 0, 0, "R1 exact");
        wr_entry(3, VA, ONES);
        search({504'b0, VA}, 0, 0, 0, "R6 lowest");
        search({504'b0, VC}, 0, 0, 0, "R6 miss");
        wr_entry(9, VC, 72'hFF);
        search({504'b0, VB[71:8], 8'h5A}, 0, 0, 0, "R1 dontcare");

        set_gmask(72'hFFFFFFFFFFFFFFFF00);
        search({504'b0, VB[71:8], 8'h01}, 0, 0, 0, "R2 partial mask");
        set_gmask(ONES);
        search({504'b0, VB}, 0, 0, 0, "R2 full mask");
        set_gmask('0);
        search({504'b0, VB[71:8], 8'h01}, 0, 0, 0, "R2 mask cleared");

        set_wmask(72'hFFFFFFFFFFFFFFFF00);
        wr_entry(3, VC, ONES);
        set_wmask('0);
        search({504'b0, VA}, 0, 0, 0, "R3 protected write");
        search({504'b0, VA[71:8], 8'h5A}, 0, 0, 0, "R3 merged entry");

        wr_tag(0, 4'd1);
        wr_tag(1, 4'd2);
        wr_entry(12, VA, ONES);
        search({504'b0, VA}, 0, 4'd2, 1'b1, "R4 tag2");
        search({504'b0, VA}, 0, 4'd1, 1'b1, "R4 tag1");
        search({504'b0, VA}, 0, 4'd7, 1'b1, "R4 no tag");
        search({504'b0, VA}, 0, 4'd7, 1'b0, "R4 tag off");

        wr_entry(16, VA, ONES);
        wr_entry(17, VB, ONES);
        wr_entry(19, VA, ONES);
        wr_entry(20, VB, ONES);
        search({432'b0, VB, VA}, 1, 0, 0, "R5 span2 aligned");
        wr_entry(17, VC, ONES);
        search({432'b0, VB, VA}, 1, 0, 0, "R5 span2 misaligned");
        for (int j = 0; j < 8; j++) wr_entry(24 + j, VC ^ KW'(j * 7 + 1), ONES);
        k = '0;
        for (int j = 0; j < 8; j++) k[j*KW +: KW] = VC ^ KW'(j * 7 + 1);
        search(k, 3, 0, 0, "R5 span8");
        search(k, 2, 0, 0, "R5 span4");
        k[0 +: KW] = VC ^ KW'(5 * 7 + 1);
        search(k, 2, 0, 0, "R5 span4 off");

        set_split(2);
        search({504'b0, VA}, 0, 0, 0, "R7 split2");
        set_split(0);
        search({504'b0, VA}, 0, 0, 0, "R7 split0");
        set_split(7);
        search({504'b0, VA}, 0, 0, 0, "R7 clamp");
        set_split(2);
        search({504'b0, VA}, 0, 0, 0, "R7 back");

        idle();
        held = res_hit;
        wr_entry(0, VA, ONES);
        idle();
        @(negedge clk);
        chk("R8 valid drops", 32'(res_valid), 32'd0);
        chk("R8 result held", 32'(res_hit), 32'(held));
        m_split = m_split;

        for (int n = 0; n < 40; n++) begin
            int w = $urandom_range(0, 3);
            k = '0;
            for (int j = 0; j < 8; j++) k[j*KW +: KW] = m_val[$urandom_range(0, N - 1)];
            if (n % 3 == 0) for (int j = 0; j < 8; j++) k[j*KW +: KW] = m_val[16 + j];
            search(k, w, 4'($urandom_range(0, 2)), 1'($urandom_range(0, 1)), "R6 mixed");
        end
        idle();
        repeat (4) @(negedge clk);
        chk("R8 queue drained", 32'(sb.size()), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule